// File: doc/BRIEF.md
# Power Mode Transition Controller

This block decides which operating mode a small processor core enters when it executes a SLEEP instruction. The core reports the instruction with a one-cycle `sleep_exec` pulse. At that moment the block samples five control bits: standby select, low-speed enable, medium-speed enable, direct-transition enable and timer clock select. From these it either parks the core in a plain sleep or watch state until an interrupt arrives, or starts a timed direct transition.

A direct transition starts from active medium-speed mode. It passes through an intermediate low-power state (sleep or watch) and ends in a new active clock mode (high-speed or subactive). The delay is counted in two clock domains. First come three ticks of the medium-speed CPU clock in force before the transition, then fourteen ticks of the CPU clock that applies after it. The block then raises a one-cycle `transition_done` pulse, which tells the core to return from the interrupt.

The oscillator and watch clocks are not generated here. They arrive as single-cycle enable strobes on the system clock, and per-mode divider selects scale them. There is no data stream through the block, so every pin is plain control or status with no handshake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset `mode` is 0 and `transition_done` is low. The `mode` codes are: 0 active high-speed, 1 active medium-speed, 2 sleep, 3 watch, 4 subactive.
- R2: A `sleep_exec` pulse in an active mode (codes 0, 1, 4) that does not select a direct path moves `mode` on the next cycle to watch (3) if standby select is 1, otherwise to sleep (2).
- R3: In a plain sleep or watch state, `wake_irq` moves `mode` on the next cycle to a mode taken from the bits sampled at SLEEP. Low-speed enable gives subactive. Otherwise medium-speed enable gives medium-speed. Otherwise the result is high-speed. No `transition_done` pulse is given.
- R4: SLEEP in medium-speed mode with direct enable 1 and standby select, low-speed enable and medium-speed enable all 0 enters sleep (2), then ends in high-speed (0) once the delay elapses.
- R5: SLEEP in medium-speed mode with direct enable, standby select, low-speed enable and timer select all 1 enters watch (3), then ends in subactive (4) once the delay elapses.
- R6: The delay has two parts. First come 3 pre-ticks: `osc_tick` divided by 2^`med_div_sel`. Then come 14 post-ticks: `osc_tick` for high-speed, or `watch_tick` divided by 2^`sub_div_sel` for subactive. Both dividers restart at SLEEP and at the switch between the parts. A tick on the SLEEP edge is not counted. `mode` changes on the edge of the final post-tick.
- R7: `transition_done` is high for exactly one cycle, on the cycle in which a direct transition lands in its final mode, and at no other time.
- R8: While in sleep or watch, further `sleep_exec` pulses are ignored, and `wake_irq` is ignored during a direct transition.
- R9: Direct enable with any other bit combination, or in a mode other than medium-speed, gives a plain entry per R2 with no timed exit.
- R10: The control bits are sampled only on the `sleep_exec` cycle. Later changes do not alter the target. The divider selects must be held stable during a transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_exec | input | 1 | One-cycle pulse: SLEEP instruction executed |
| stby_sel | input | 1 | Standby select bit |
| lspd_on | input | 1 | Low-speed enable bit |
| mspd_on | input | 1 | Medium-speed enable bit |
| direct_on | input | 1 | Direct-transition enable bit |
| tmr_sel | input | 1 | Timer clock select bit |
| osc_tick | input | 1 | Oscillator clock enable strobe |
| watch_tick | input | 1 | Watch clock enable strobe |
| med_div_sel | input | 2 | Medium-speed divider select (divide by 2^value) |
| sub_div_sel | input | 2 | Subactive divider select (divide by 2^value) |
| wake_irq | input | 1 | Interrupt that ends a plain sleep or watch |
| mode | output | 3 | Current operating mode code |
| transition_done | output | 1 | One-cycle pulse at the end of a direct transition |

## Verification
The assertions check the following on every cycle. `mode` always holds a legal code. An active mode changes only on `sleep_exec`, and only into sleep or watch. An intermediate state is left only through `wake_irq` or a completion pulse. The completion pulse lasts one cycle and lands in high-speed or subactive. The exact delay depends on the tick patterns and divider settings, so only the bench's scenarios can show it. The same holds for bits being sampled once at SLEEP and for the difference between the direct and plain paths. The bench computes the landing cycle for each pattern and checks every cycle of the wait.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic [2:0] {
    MODE_HIGH  = 3'd0,
    MODE_MED   = 3'd1,
    MODE_SLEEP = 3'd2,
    MODE_WATCH = 3'd3,
    MODE_SUB   = 3'd4
  } pmt_mode_e;

  function automatic logic is_intermediate(input pmt_mode_e m);
    return (m == MODE_SLEEP) || (m == MODE_WATCH);
  endfunction
endpackage

// File: rtl/pmt_decode.sv
module pmt_decode
  import pmt_pkg::*;
(
  input  pmt_mode_e cur_mode,
  input  logic      stby_sel,
  input  logic      lspd_on,
  input  logic      mspd_on,
  input  logic      direct_on,
  input  logic      tmr_sel,
  output pmt_mode_e enter_mode,
  output pmt_mode_e target_mode,
  output logic      is_direct
);
  logic in_med, dir_hi, dir_sub;

  always_comb begin
    in_med  = (cur_mode == MODE_MED);
    // R4: direct path to high-speed through sleep
    dir_hi  = in_med && direct_on && !stby_sel && !lspd_on && !mspd_on;
    // R5: direct path to subactive through watch
    dir_sub = in_med && direct_on && stby_sel && lspd_on && tmr_sel;
    is_direct = dir_hi || dir_sub;

    if (dir_hi)        enter_mode = MODE_SLEEP;
    else if (dir_sub)  enter_mode = MODE_WATCH;
    else if (stby_sel) enter_mode = MODE_WATCH;
    else               enter_mode = MODE_SLEEP;

    if (dir_hi)        target_mode = MODE_HIGH;
    else if (dir_sub)  target_mode = MODE_SUB;
    else if (lspd_on)  target_mode = MODE_SUB;
    else if (mspd_on)  target_mode = MODE_MED;
    else               target_mode = MODE_HIGH;
  end
endmodule

// File: rtl/pmt_tick_div.sv
module pmt_tick_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick_in,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick_out
);
  localparam int PW = ((1 << SEL_W) - 1) > 0 ? ((1 << SEL_W) - 1) : 1;

  logic [PW-1:0] pcnt, last;

  always_comb begin
    last     = PW'((32'd1 << div_sel) - 32'd1);
    tick_out = tick_in && (pcnt == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (clear)    pcnt <= '0;
    else if (tick_out) pcnt <= '0;
    else if (tick_in)  pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/pmt_delay_cnt.sv
module pmt_delay_cnt #(
  parameter int PRE_TICKS  = 3,
  parameter int POST_TICKS = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic pre_phase,
  output logic phase_switch,
  output logic finish
);
  localparam int TOTAL = PRE_TICKS + POST_TICKS;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_comb begin
    pre_phase    = (cnt < CW'(PRE_TICKS));
    phase_switch = run && tick && (cnt == CW'(PRE_TICKS - 1));
    finish       = run && tick && (cnt == CW'(TOTAL - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (finish) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (run && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmt_pkg::*;
#(
  parameter int DIV_SEL_W  = 2,
  parameter int PRE_TICKS  = 3,
  parameter int POST_TICKS = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep_exec,
  input  logic                 stby_sel,
  input  logic                 lspd_on,
  input  logic                 mspd_on,
  input  logic                 direct_on,
  input  logic                 tmr_sel,
  input  logic                 osc_tick,
  input  logic                 watch_tick,
  input  logic [DIV_SEL_W-1:0] med_div_sel,
  input  logic [DIV_SEL_W-1:0] sub_div_sel,
  input  logic                 wake_irq,
  output logic [2:0]           mode,
  output logic                 transition_done
);
  pmt_mode_e mode_q, tgt_q, enter_m, target_m;
  logic      direct_q, is_direct, done_q;
  logic      in_inter, start, pre_phase, phase_switch, finish;
  logic      div_clear, div_in, div_out, post_hi;
  logic [DIV_SEL_W-1:0] div_sel;

  pmt_decode u_dec (
    .cur_mode   (mode_q),
    .stby_sel   (stby_sel),
    .lspd_on    (lspd_on),
    .mspd_on    (mspd_on),
    .direct_on  (direct_on),
    .tmr_sel    (tmr_sel),
    .enter_mode (enter_m),
    .target_mode(target_m),
    .is_direct  (is_direct)
  );

  always_comb begin
    in_inter  = is_intermediate(mode_q);
    start     = sleep_exec && !in_inter && is_direct;
    post_hi   = (tgt_q == MODE_HIGH);
    div_clear = start || phase_switch;
    // R6: pre-transition clock first, then the clock of the target mode
    if (pre_phase) begin
      div_in  = osc_tick;
      div_sel = med_div_sel;
    end else if (post_hi) begin
      div_in  = osc_tick;
      div_sel = '0;
    end else begin
      div_in  = watch_tick;
      div_sel = sub_div_sel;
    end
  end

  pmt_tick_div #(.SEL_W(DIV_SEL_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (div_clear),
    .tick_in (div_in),
    .div_sel (div_sel),
    .tick_out(div_out)
  );

  pmt_delay_cnt #(.PRE_TICKS(PRE_TICKS), .POST_TICKS(POST_TICKS)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .tick        (div_out),
    .pre_phase   (pre_phase),
    .phase_switch(phase_switch),
    .finish      (finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_HIGH;
      tgt_q    <= MODE_HIGH;
      direct_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!in_inter) begin
        // R2, R9, R10: bits sampled only here
        if (sleep_exec) begin
          mode_q   <= enter_m;
          tgt_q    <= target_m;
          direct_q <= is_direct;
        end
      end else if (direct_q) begin
        // R8: wake_irq and sleep_exec ignored while timing
        if (finish) begin
          mode_q   <= tgt_q;
          direct_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end else if (wake_irq) begin
        mode_q <= tgt_q;
      end
    end
  end

  assign mode            = mode_q;
  assign transition_done = done_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_exec,
  input logic       wake_irq,
  input logic [2:0] mode,
  input logic       transition_done
);
  logic inter, active;
  assign inter  = (mode == 3'd2) || (mode == 3'd3);
  assign active = (mode == 3'd0) || (mode == 3'd1) || (mode == 3'd4);

  // R1
  legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);

  // R2
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sleep_exec) |=> (mode == $past(mode)));

  // R2
  active_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sleep_exec) |=> ((mode == 3'd2) || (mode == 3'd3)));

  // R8
  inter_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inter && !wake_irq) |=> ((mode == $past(mode)) || transition_done));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    transition_done |=> !transition_done);

  // R7
  done_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    transition_done |-> ((mode == 3'd0) || (mode == 3'd4)));

  // R7
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    transition_done |-> (($past(mode) == 3'd2) || ($past(mode) == 3'd3)));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sleep_exec     (sleep_exec),
  .wake_irq       (wake_irq),
  .mode           (mode),
  .transition_done(transition_done)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_exec = 0, stby_sel = 0, lspd_on = 0, mspd_on = 0;
  logic direct_on = 0, tmr_sel = 0, osc_tick = 0, watch_tick = 0, wake_irq = 0;
  logic [1:0] med_div_sel = 0, sub_div_sel = 0;
  logic [2:0] mode;
  logic transition_done;
  int checks = 0, errors = 0;

  localparam logic [2:0] M_HIGH = 0, M_MED = 1, M_SLEEP = 2, M_WATCH = 3, M_SUB = 4;

  always #2 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .stby_sel(stby_sel),
    .lspd_on(lspd_on), .mspd_on(mspd_on), .direct_on(direct_on), .tmr_sel(tmr_sel),
    .osc_tick(osc_tick), .watch_tick(watch_tick), .med_div_sel(med_div_sel),
    .sub_div_sel(sub_div_sel), .wake_irq(wake_irq), .mode(mode),
    .transition_done(transition_done)
  );

  task automatic chk(input string req, input logic [2:0] m_exp, input logic d_exp);
    checks++;
    if (mode !== m_exp || transition_done !== d_exp) begin
      errors++;
      $display("FAIL %s: mode=%0d done=%0b expected mode=%0d done=%0b",
               req, mode, transition_done, m_exp, d_exp);
    end
  endtask

  // Edge index (after the SLEEP edge) at which the direct transition lands.
  function automatic int land_edge(input int op, input int msel, input int wp,
                                   input int ssel, input bit to_sub);
    int kpre;
    kpre = 3 * (1 << msel) * op;
    if (!to_sub) return kpre + 14 * op;
    return ((kpre / wp) + 14 * (1 << ssel)) * wp;
  endfunction

  function automatic logic [2:0] plain_target(input logic l, input logic m);
    if (l) return M_SUB;
    if (m) return M_MED;
    return M_HIGH;
  endfunction

  task automatic set_bits(input logic s, input logic l, input logic m,
                          input logic d, input logic t);
    stby_sel = s; lspd_on = l; mspd_on = m; direct_on = d; tmr_sel = t;
  endtask

  // Plain entry, spurious SLEEP pulses, hold, then wake.
  task automatic plain_cycle(input logic d, input logic s, input logic l,
                             input logic m, input int hold, input string req);
    logic [2:0] inter_m, tgt;
    inter_m = s ? M_WATCH : M_SLEEP;
    tgt = plain_target(l, m);
    @(negedge clk);
    set_bits(s, l, m, d, 1'b1);
    osc_tick = 1; watch_tick = 1; sleep_exec = 1; wake_irq = 0;
    @(posedge clk); #1;
    chk({req, "/R2 entry"}, inter_m, 1'b0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      sleep_exec = 1'($urandom_range(0, 1));
      set_bits(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      @(posedge clk); #1;
      if (i == hold - 1) chk({req, "/R8 R10 hold"}, inter_m, 1'b0);
    end
    @(negedge clk);
    sleep_exec = 0; wake_irq = 1;
    @(posedge clk); #1;
    chk("R3 wake", tgt, 1'b0);
    @(negedge clk);
    wake_irq = 0;
  endtask

  task automatic direct_run(input bit to_sub, input int op, input int msel,
                            input int wp, input int ssel, input string req);
    int n;
    logic [2:0] inter_m, tgt;
    bit bad;
    inter_m = to_sub ? M_WATCH : M_SLEEP;
    tgt = to_sub ? M_SUB : M_HIGH;
    n = land_edge(op, msel, wp, ssel, to_sub);
    @(negedge clk);
    med_div_sel = 2'(msel); sub_div_sel = 2'(ssel);
    if (to_sub) set_bits(1, 1, 0, 1, 1); else set_bits(0, 0, 0, 1, 0);
    osc_tick = 1; watch_tick = 1; sleep_exec = 1; wake_irq = 0;
    @(posedge clk); #1;
    chk({req, " entry"}, inter_m, 1'b0);
    bad = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      osc_tick = (k % op) == 0;
      watch_tick = (k % wp) == 0;
      sleep_exec = 1'($urandom_range(0, 1));
      wake_irq = 1'($urandom_range(0, 1));
      set_bits(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      @(posedge clk); #1;
      if (k < n && !bad && (mode !== inter_m || transition_done !== 1'b0)) begin
        bad = 1;
        chk("R6 R8 R10 wait", inter_m, 1'b0);
      end
    end
    chk({req, "/R6 land"}, tgt, 1'b1);
    @(negedge clk);
    sleep_exec = 0; wake_irq = 0; set_bits(0, 0, 0, 0, 0);
    osc_tick = 1; watch_tick = 1;
    @(posedge clk); #1;
    chk("R7 one cycle", tgt, 1'b0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", M_HIGH, 1'b0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 idle", M_HIGH, 1'b0);

    // R9: direct bits in high-speed mode give a plain entry
    plain_cycle(1, 0, 0, 1, 40, "R9 from high");
    // R4: directed, 38 edges when dividing by 8
    if (land_edge(1, 3, 1, 0, 0) != 38) begin
      errors++; $display("FAIL R4 formula: got %0d expected 38", land_edge(1, 3, 1, 0, 0));
    end
    direct_run(0, 1, 3, 1, 0, "R4 hi");
    plain_cycle(0, 1, 0, 1, 4, "R2 watch");
    // R5: directed, 24 + 112 edges
    direct_run(1, 1, 3, 1, 3, "R5 sub");
    plain_cycle(0, 0, 0, 1, 4, "R2 from sub");
    // R9: medium mode, direct bit but non-matching combination
    plain_cycle(1, 0, 0, 1, 80, "R9 mismatch");
    plain_cycle(0, 0, 1, 0, 3, "R3 to sub");
    plain_cycle(0, 0, 0, 1, 3, "R3 to med");

    for (int it = 0; it < 20; it++) begin
      bit sub;
      sub = 1'($urandom);
      direct_run(sub, $urandom_range(1, 3), $urandom_range(0, 3),
                 $urandom_range(1, 4), $urandom_range(0, 3),
                 sub ? "R5 rand" : "R4 rand");
      plain_cycle(0, 1'($urandom), 0, 1, 2, "R3 back");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule